// File: doc/BRIEF.md
# Transmit FIFO threshold start controller

This block sits next to the transmit FIFO of an Ethernet MAC and decides the moment at which the transmitter may begin sending a frame that is still being written into the FIFO. It counts the bytes of the current frame as the writer pushes them. It compares that count against a byte threshold picked by a 3-bit code. When the count passes the threshold, or when the writer marks the frame as completely written, it raises a one-cycle start pulse to the transmitter.

A store-and-forward mode disables the threshold. In that mode the start pulse waits until the whole frame is in the FIFO. The threshold code and the mode flag are held in a small configuration register, which is loaded by a write strobe. The transmitter reports the end of each frame with a done strobe. That strobe clears the byte count, the end-of-frame flag and the per-frame started flag, so the controller is ready for the next frame. A write in the same cycle as the done strobe is taken as the first write of the next frame.

Top module: `txThreshStart`

## Requirements
- R1: Threshold codes with bit 2 clear select (code+1)×64 bytes: 0→64, 1→128, 2→192, 3→256.
- R2: Threshold codes with bit 2 set select 40 − 8×(code[1:0]) bytes: 4→40, 5→32, 6→24, 7→16.
- R3: With store-and-forward off, `txStart` is high in the cycle after the write that makes the frame's byte count strictly greater than the threshold. A count equal to the threshold does not start.
- R4: A frame whose last write (`wrLast` with `wrValid`) arrives while its count is at or below the threshold still raises `txStart` in the cycle after that write.
- R5: With store-and-forward on, the threshold has no effect, and `txStart` rises only in the cycle after the last write of the frame.
- R6: After reset the threshold code is 0 (64 bytes) and store-and-forward is off. `cfgWr` loads `cfgThr` and `cfgSf`, which take effect from the following cycle.
- R7: `txStart` lasts exactly one cycle and occurs at most once per frame, whatever further writes arrive before `txDone`.
- R8: `txDone` clears the byte count, the end-of-frame flag and the started flag. A write in the same cycle as `txDone` becomes the first write of the next frame.
- R9: The byte count saturates at 2^CNT_W − 1 and never wraps.
- R10: During reset and in the first cycle after reset, `txStart` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Load strobe for the threshold code and mode |
| cfgThr | input | 3 | Threshold select code |
| cfgSf | input | 1 | Store-and-forward mode flag |
| wrValid | input | 1 | Bytes of the current frame were written to the FIFO this cycle |
| wrBytes | input | WB_W | Number of bytes written this cycle (0 to BUS_BYTES) |
| wrLast | input | 1 | This write completes the frame |
| txDone | input | 1 | Transmitter finished the current frame |
| txStart | output | 1 | One-cycle pulse: transmission of the frame may begin |

## Verification
Every result of this block is due one clock after the edge that captures its cause. That cause may be a write that pushes the count past the threshold, the last write of a frame, a configuration load, or a done strobe. The output is decoded from registers only, so inputs changed after that edge cannot disturb it. The driver applies inputs just after a rising edge and computes the expected start level from its own model of count, end-of-frame, mode and started state once the next edge has passed. It then queues that level. The monitor pops the queued level at the falling edge half a cycle later and compares it with `txStart`, so every cycle of every scenario is checked at the one point where its value is settled.

// File: rtl/txts_pkg.sv
package txts_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrFrame;
    logic cntEn;
  } ctlStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic overThr;
    logic eofSeen;
    logic sfActive;
  } dpStatus_t;

  // Byte threshold for a select code; low half steps up by 64, high half steps down by 8 from 40
  function automatic logic [8:0] thrBytes(input logic [2:0] code);
    logic [8:0] idx;
    idx = {7'd0, code[1:0]};
    if (!code[2]) return (idx + 9'd1) << 6;
    else          return 9'd40 - (idx << 3);
  endfunction

endpackage

// File: rtl/txThreshDatapath.sv
module txThreshDatapath
  import txts_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int BUS_BYTES = 8,
  localparam int WB_W     = $clog2(BUS_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWr,
  input  logic [2:0]      cfgThr,
  input  logic            cfgSf,
  input  logic [WB_W-1:0] wrBytes,
  input  logic            wrLast,
  input  ctlStrobe_t      strb,
  output dpStatus_t       stat
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [2:0]       thrCode;
  logic             sfQ;
  logic [CNT_W-1:0] byteCnt;
  logic             eofSeen;
  logic [CNT_W:0]   sumWide;
  logic [CNT_W-1:0] satCnt;
  logic [CNT_W-1:0] thrWide;

  always_comb begin
    sumWide = {1'b0, byteCnt} + (CNT_W + 1)'(wrBytes);
    satCnt  = sumWide[CNT_W] ? CNT_MAX : sumWide[CNT_W-1:0];
    thrWide = CNT_W'(thrBytes(thrCode));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrCode <= 3'd0;
      sfQ     <= 1'b0;
      byteCnt <= '0;
      eofSeen <= 1'b0;
    end else begin
      if (cfgWr) begin
        thrCode <= cfgThr;
        sfQ     <= cfgSf;
      end
      if (strb.clrFrame) begin
        byteCnt <= strb.cntEn ? CNT_W'(wrBytes) : '0;
        eofSeen <= strb.cntEn & wrLast;
      end else if (strb.cntEn) begin
        byteCnt <= satCnt;
        eofSeen <= eofSeen | wrLast;
      end
    end
  end

  always_comb begin
    stat.overThr  = byteCnt > thrWide;
    stat.eofSeen  = eofSeen;
    stat.sfActive = sfQ;
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (byteCnt == CNT_MAX && strb.cntEn && !strb.clrFrame) |=> byteCnt == CNT_MAX); // R9

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrFrame |=> byteCnt >= $past(byteCnt)); // R9

  AST_FRAME_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFrame && !strb.cntEn) |=> (byteCnt == '0 && !eofSeen)); // R8

endmodule

// File: rtl/txThreshControl.sv
module txThreshControl
  import txts_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       txDone,
  input  dpStatus_t  stat,
  output ctlStrobe_t strb,
  output logic       txStart
);

  logic started;
  logic goReady;

  always_comb begin
    strb.clrFrame = txDone;
    strb.cntEn    = wrValid;
    goReady       = stat.eofSeen | (!stat.sfActive & stat.overThr);
    txStart       = goReady & !started;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         started <= 1'b0;
    else if (txDone)   started <= 1'b0;
    else if (txStart)  started <= 1'b1;
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (txStart && !txDone) |=> !txStart); // R7

  AST_SF_WAITS_EOF: assert property (@(posedge clk) disable iff (!rstN)
    (stat.sfActive && !stat.eofSeen) |-> !txStart); // R5

  AST_START_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> (stat.eofSeen || stat.overThr)); // R3

endmodule

// File: rtl/txThreshStart.sv
module txThreshStart
  import txts_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int BUS_BYTES = 8,
  localparam int WB_W     = $clog2(BUS_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWr,
  input  logic [2:0]      cfgThr,
  input  logic            cfgSf,
  input  logic            wrValid,
  input  logic [WB_W-1:0] wrBytes,
  input  logic            wrLast,
  input  logic            txDone,
  output logic            txStart
);

  ctlStrobe_t strb;
  dpStatus_t  stat;

  txThreshDatapath #(
    .CNT_W    (CNT_W),
    .BUS_BYTES(BUS_BYTES)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .cfgWr  (cfgWr),
    .cfgThr (cfgThr),
    .cfgSf  (cfgSf),
    .wrBytes(wrBytes),
    .wrLast (wrLast),
    .strb   (strb),
    .stat   (stat)
  );

  txThreshControl uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .wrValid(wrValid),
    .txDone (txDone),
    .stat   (stat),
    .strb   (strb),
    .txStart(txStart)
  );

endmodule

// File: tb/sim_txThreshStart.sv
module sim_txThreshStart;

  localparam int CNT_W     = 12;
  localparam int BUS_BYTES = 8;
  localparam int WB_W      = $clog2(BUS_BYTES + 1);
  localparam int CNT_MAX   = (1 << CNT_W) - 1;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cfgWr = 1'b0;
  logic [2:0]      cfgThr = 3'd0;
  logic            cfgSf = 1'b0;
  logic            wrValid = 1'b0;
  logic [WB_W-1:0] wrBytes = '0;
  logic            wrLast = 1'b0;
  logic            txDone = 1'b0;
  logic            txStart;

  always #2 clk = ~clk;  // 250 MHz

  txThreshStart #(.CNT_W(CNT_W), .BUS_BYTES(BUS_BYTES)) u0 (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgThr(cfgThr), .cfgSf(cfgSf),
    .wrValid(wrValid), .wrBytes(wrBytes), .wrLast(wrLast), .txDone(txDone),
    .txStart(txStart)
  );

  typedef struct {
    bit    exp;
    string req;
  } item_t;

  item_t sbq[$];
  int    checks = 0;
  int    errors = 0;

  // bench model
  int     mCnt = 0;
  bit     mEof = 0, mStarted = 0, mSf = 0, mPrev = 0;
  bit [2:0] mCode = 0;

  function automatic int thrOf(bit [2:0] c);
    if (c < 4) return (int'(c) + 1) * 64;
    return 40 - 8 * (int'(c) - 4);
  endfunction

  // monitor
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (txStart !== it.exp) begin
        errors++;
        $display("FAIL %s txStart actual=%0b expected=%0b at %0t", it.req, txStart, it.exp, $time);
      end
    end
  end

  // driver: one cycle of stimulus, then queue the expected level
  task automatic step(bit wv, int nb, bit last, bit done, bit cw, bit [2:0] ct, bit cs, string req);
    item_t it;
    wrValid = wv; wrBytes = WB_W'(nb); wrLast = last; txDone = done;
    cfgWr = cw; cfgThr = ct; cfgSf = cs;
    @(posedge clk); #1;
    if (cw) begin mCode = ct; mSf = cs; end
    if (done) begin
      mCnt = wv ? nb : 0; mEof = wv && last; mStarted = 0;
    end else begin
      mStarted = mStarted | mPrev;
      if (wv) begin
        mCnt = (mCnt + nb > CNT_MAX) ? CNT_MAX : mCnt + nb;
        mEof = mEof | last;
      end
    end
    it.exp = !mStarted && (mEof || (!mSf && mCnt > thrOf(mCode)));
    it.req = req;
    mPrev  = it.exp;
    sbq.push_back(it);
    wrValid = 0; wrLast = 0; txDone = 0; cfgWr = 0;
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 3'd0, 0, req);
  endtask

  task automatic write(int nb, bit last, string req);
    step(1, nb, last, 0, 0, 3'd0, 0, req);
  endtask

  task automatic done(string req);
    step(0, 0, 0, 1, 0, 3'd0, 0, req);
  endtask

  task automatic cfg(bit [2:0] ct, bit cs, string req);
    step(0, 0, 0, 0, 1, ct, cs, req);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pulses;
    // R10: output low during reset
    repeat (3) @(negedge clk);
    checks++;
    if (txStart !== 1'b0) begin
      errors++;
      $display("FAIL R10 txStart in reset actual=%0b expected=0", txStart);
    end
    @(posedge clk); #1; rstN = 1;
    idle(2, "R10");

    // R6 default 64, R3 equal does not start, one more byte starts
    for (int i = 0; i < 8; i++) write(8, 0, "R6");
    write(1, 0, "R3");
    // R7: further writes and last produce no second pulse
    for (int i = 0; i < 5; i++) write(8, 0, "R7");
    write(4, 1, "R7");
    idle(3, "R7");
    done("R8");
    idle(2, "R8");

    // R1/R2: every code, one byte per cycle until start
    for (int c = 0; c < 8; c++) begin
      cfg(3'(c), 0, (c < 4) ? "R1" : "R2");
      pulses = 0;
      for (int i = 0; i < 300 && pulses == 0; i++) begin
        write(1, 0, (c < 4) ? "R1" : "R2");
        if (mPrev) pulses = 1;
      end
      if (mCnt != thrOf(3'(c)) + 1) begin
        checks++; errors++;
        $display("FAIL %s start byte actual=%0d expected=%0d", (c < 4) ? "R1" : "R2", mCnt, thrOf(3'(c)) + 1);
      end
      idle(2, "R7");
      done("R8");
    end

    // R4: short complete frame below 64-byte threshold
    cfg(3'd0, 0, "R6");
    write(8, 0, "R4");
    write(8, 0, "R4");
    write(4, 1, "R4");
    idle(2, "R4");
    done("R4");

    // R5: store-and-forward ignores the 16-byte threshold
    cfg(3'd7, 1, "R5");
    for (int i = 0; i < 12; i++) write(8, 0, "R5");
    idle(3, "R5");
    write(3, 1, "R5");
    idle(2, "R5");
    done("R5");

    // R8: write in the done cycle counts for the next frame
    cfg(3'd7, 0, "R8");
    write(8, 0, "R8");
    write(8, 0, "R8");
    idle(1, "R8");
    step(1, 8, 0, 1, 0, 3'd0, 0, "R8");
    write(8, 0, "R8");
    write(1, 0, "R8");
    idle(2, "R8");
    done("R8");

    // R9: fill past the counter range in store-and-forward, then switch mode
    cfg(3'd0, 1, "R9");
    for (int i = 0; i < 520; i++) write(8, 0, "R9");
    cfg(3'd0, 0, "R9");
    idle(2, "R9");
    done("R9");
    idle(3, "R9");

    @(negedge clk); @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule